// File: doc/BRIEF.md
# Four-Plane Raster Operation Unit

This block sits on the path between a processor bus and four bit-plane video memories: blue, red, green and an extra plane. Each plane has a tile pattern register. Every processor access to plane memory passes through the block, which turns it into one of three raster operations:

- A tile write fills the enabled planes with their tile bytes.
- A masked merge write blends the tile into memory under a bit mask taken from the processor data.
- A compare read reports which pixels match the tile in every enabled plane.

The plane memories are held inside the block as two page sets of synchronous RAM. Each set has four planes of `2**PLANE_AW` bytes. A separate display read port returns all four planes of one address at once. After each processor write, an update strobe names the page and the byte address that was touched, so that a display refresher can track dirty locations.

Configuration uses a small write port. Select 0 writes the mode register. Selects 1 to 4 write the blue, red, green and extra tile registers. In the mode register, bits 3:0 disable individual planes and bit 4 chooses between the two operating modes: tile mode (tile writes and compare reads) and merge mode (masked merge writes and plain reads).

Top module: `plane_rop`

## Requirements
- R1: Mode bits 0, 1, 2 and 3 disable the blue, red, green and extra planes respectively. A disabled plane is left unwritten by every write and is left out of every compare.
- R2: With mode bit 4 clear, a write stores the low byte of each enabled plane's tile register at the target address. The processor write data is ignored.
- R3: With mode bit 4 set, a write treats the processor data as a mask. Each enabled plane byte becomes (old & ~mask) | (mask & tile low byte).
- R4: With mode bit 4 clear, a byte read returns ~(OR over the enabled planes of (plane byte ^ tile low byte)) in bits 7:0.
- R5: A word write (`cpu_word`=1) updates plane addresses a and a+1, with the address wrapping within the plane. Both bytes use the same tile low byte. Data bits 7:0 are the mask for address a and bits 15:8 are the mask for address a+1.
- R6: A word compare read uses the full 16-bit tile register against the plane word {byte a+1, byte a}.
- R7: With mode bit 4 set, reads return plain plane data with no comparison. `cpu_addr[PLANE_AW+1:PLANE_AW]` selects the plane: 0 blue, 1 red, 2 green, 3 extra. Word reads are little-endian.
- R8: The plane address is `cpu_addr[PLANE_AW-1:0]`, and `cpu_page` selects one of the two page sets. `disp_rdata` returns {extra, green, red, blue} for `disp_page`/`disp_addr` one cycle after they are presented.
- R9: One cycle after every write, `upd_valid` pulses high with `upd_page`, `upd_addr` (the lower address) and `upd_two` (set for a word write). `upd_valid` stays low in every other cycle.
- R10: With all four planes disabled, a compare read returns 0x00FF for a byte read or 0xFFFF for a word read, and writes leave every plane unchanged.
- R11: `cpu_rdata` and `cpu_rvalid` are registered one cycle after a read request. `cpu_rvalid` is high only in that cycle. A byte read returns 0 in bits 15:8.
- R12: Reset clears the mode register, all tile registers, `cpu_rdata`, `cpu_rvalid` and `upd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0 mode, 1 blue tile, 2 red tile, 3 green tile, 4 extra tile |
| cfg_wdata | input | 16 | Configuration data (mode uses bits 4:0) |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_word | input | 1 | 1 word access, 0 byte access |
| cpu_page | input | 1 | Plane page set select |
| cpu_addr | input | PLANE_AW+2 | Plane address in the low bits, plain-read plane select in the top two bits |
| cpu_wdata | input | 16 | Write data or merge mask |
| cpu_rdata | output | 16 | Read result |
| cpu_rvalid | output | 1 | Read result valid |
| disp_page | input | 1 | Display read page |
| disp_addr | input | PLANE_AW | Display read address |
| disp_rdata | output | 32 | {extra, green, red, blue} bytes |
| upd_valid | output | 1 | Write update strobe |
| upd_page | output | 1 | Page of the written bytes |
| upd_addr | output | PLANE_AW | Lower written address |
| upd_two | output | 1 | Two bytes were written |

## Verification
The hardest case to reach is a word compare in which each plane disagrees with its tile in different bits of each byte. Only that case shows whether the 16-bit tile value and the little-endian assembly are both honoured. To set it up, the vectors first fill a word with tile writes. They then reshape that word with a merge write under a split mask, so that the two bytes hold different values. Finally they compare it with all planes enabled and again with one plane enabled. Address wrap at the top of a plane is reached by a word write at the last byte address. The display port then shows that address zero of the same page was written.

// File: rtl/plane_rop.sv
module plane_rop #(
  parameter int PLANE_AW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_sel,
  input  logic [15:0]           cfg_wdata,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic                  cpu_word,
  input  logic                  cpu_page,
  input  logic [PLANE_AW+1:0]   cpu_addr,
  input  logic [15:0]           cpu_wdata,
  output logic [15:0]           cpu_rdata,
  output logic                  cpu_rvalid,
  input  logic                  disp_page,
  input  logic [PLANE_AW-1:0]   disp_addr,
  output logic [31:0]           disp_rdata,
  output logic                  upd_valid,
  output logic                  upd_page,
  output logic [PLANE_AW-1:0]   upd_addr,
  output logic                  upd_two
);
  localparam int DEPTH = 1 << PLANE_AW;

  logic [4:0]  mode_q;
  logic [15:0] tile_q [4];
  logic [7:0]  pmem [2][4][DEPTH];

  logic [PLANE_AW-1:0] a0, a1;
  logic [1:0]  psel;
  logic        merge;
  logic [15:0] pw [4];
  logic [7:0]  nb0 [4];
  logic [7:0]  nb1 [4];
  logic [15:0] diff, cmp_val, plain_val, rd_next;

  assign a0    = cpu_addr[PLANE_AW-1:0];
  assign a1    = a0 + 1'b1;
  assign psel  = cpu_addr[PLANE_AW+1:PLANE_AW];
  assign merge = mode_q[4];

  always_comb begin
    diff = '0;
    for (int p = 0; p < 4; p++) begin
      pw[p] = {pmem[cpu_page][p][a1], pmem[cpu_page][p][a0]};
      if (merge) begin
        nb0[p] = (pw[p][7:0]  & ~cpu_wdata[7:0])  | (cpu_wdata[7:0]  & tile_q[p][7:0]);
        nb1[p] = (pw[p][15:8] & ~cpu_wdata[15:8]) | (cpu_wdata[15:8] & tile_q[p][7:0]);
      end else begin
        nb0[p] = tile_q[p][7:0];
        nb1[p] = tile_q[p][7:0];
      end
      if (!mode_q[p])
        diff = diff | (pw[p] ^ (cpu_word ? tile_q[p] : {8'h00, tile_q[p][7:0]}));
    end
  end

  assign cmp_val   = cpu_word ? ~diff : {8'h00, ~diff[7:0]};
  assign plain_val = cpu_word ? pw[psel] : {8'h00, pw[psel][7:0]};
  assign rd_next   = merge ? plain_val : cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      for (int t = 0; t < 4; t++) tile_q[t] <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0:    mode_q    <= cfg_wdata[4:0];
        3'd1:    tile_q[0] <= cfg_wdata;
        3'd2:    tile_q[1] <= cfg_wdata;
        3'd3:    tile_q[2] <= cfg_wdata;
        3'd4:    tile_q[3] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_req && cpu_we) begin
      for (int p = 0; p < 4; p++) begin
        if (!mode_q[p]) begin
          pmem[cpu_page][p][a0] <= nb0[p];
          if (cpu_word) pmem[cpu_page][p][a1] <= nb1[p];
        end
      end
    end
    disp_rdata <= {pmem[disp_page][3][disp_addr], pmem[disp_page][2][disp_addr],
                   pmem[disp_page][1][disp_addr], pmem[disp_page][0][disp_addr]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
      upd_valid  <= 1'b0;
      upd_page   <= 1'b0;
      upd_addr   <= '0;
      upd_two    <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_req && !cpu_we;
      if (cpu_req && !cpu_we) cpu_rdata <= rd_next;
      upd_valid <= cpu_req && cpu_we;
      if (cpu_req && cpu_we) begin
        upd_page <= cpu_page;
        upd_addr <= a0;
        upd_two  <= cpu_word;
      end
    end
  end
endmodule

// File: rtl/plane_rop_chk.sv
module plane_rop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_word,
  input logic        cpu_page,
  input logic [15:0] cpu_rdata,
  input logic        cpu_rvalid,
  input logic        upd_valid,
  input logic        upd_page,
  input logic        upd_two,
  input logic [4:0]  mode
);
  // R11
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> cpu_rvalid);
  // R11
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we) |=> !cpu_rvalid);
  // R11
  byte_read_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_word) |=> cpu_rdata[15:8] == 8'h00);
  // R10
  all_off_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && mode == 5'h0F) |=>
      cpu_rdata == ($past(cpu_word) ? 16'hFFFF : 16'h00FF));
  // R9
  upd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |=>
      (upd_valid && upd_page == $past(cpu_page) && upd_two == $past(cpu_word)));
  // R9
  upd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && cpu_we) |=> !upd_valid);
  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!cpu_rvalid && !upd_valid && mode == 5'h00));
endmodule

bind plane_rop plane_rop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_word(cpu_word), .cpu_page(cpu_page), .cpu_rdata(cpu_rdata),
  .cpu_rvalid(cpu_rvalid), .upd_valid(upd_valid), .upd_page(upd_page),
  .upd_two(upd_two), .mode(mode_q)
);

// File: tb/plane_rop_bench.sv
`timescale 1ns/1ps
module plane_rop_bench;
  localparam int AW  = 8;
  localparam int CAW = AW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0, cpu_page = 1'b0;
  logic [CAW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic cpu_rvalid;
  logic disp_page = 1'b0;
  logic [AW-1:0] disp_addr = '0;
  logic [31:0] disp_rdata;
  logic upd_valid, upd_page, upd_two;
  logic [AW-1:0] upd_addr;

  plane_rop #(.PLANE_AW(AW)) u_plane_rop (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_page(cpu_page),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .disp_page(disp_page), .disp_addr(disp_addr), .disp_rdata(disp_rdata),
    .upd_valid(upd_valid), .upd_page(upd_page), .upd_addr(upd_addr), .upd_two(upd_two)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // kind: 0 config (select in addr[2:0]), 1 write, 2 read check, 3 display check
  function automatic logic [65:0] mk(int kind, int rq, bit pg, bit wd,
                                     logic [9:0] ad, logic [15:0] dt, logic [31:0] ex);
    return {2'(kind), 4'(rq), pg, wd, ad, dt, ex};
  endfunction

  localparam int NV = 47;
  localparam logic [65:0] VEC [NV] = '{
    mk(0,0,0,0,10'h001,16'h12F0,0), mk(0,0,0,0,10'h002,16'h340F,0),
    mk(0,0,0,0,10'h003,16'h56FF,0), mk(0,0,0,0,10'h004,16'h7800,0),
    mk(0,0,0,0,10'h000,16'h0000,0),
    mk(1,0,0,0,10'h010,16'h1234,0),
    mk(3,2,0,0,10'h010,0,32'h00FF0FF0),        // R2 data ignored
    mk(2,4,0,0,10'h010,0,32'h000000FF),        // R4 full match
    mk(0,0,0,0,10'h001,16'h0000,0), mk(0,0,0,0,10'h000,16'h0010,0),
    mk(1,0,0,0,10'h010,16'h003C,0),
    mk(3,3,0,0,10'h010,0,32'h00FF0FC0),        // R3 masked merge
    mk(2,7,0,0,10'h010,0,32'h000000C0),        // R7 plain blue
    mk(2,7,0,0,10'h110,0,32'h0000000F),        // R7 plain red
    mk(0,0,0,0,10'h000,16'h0000,0),
    mk(1,0,0,1,10'h020,16'h5555,0),
    mk(0,0,0,0,10'h000,16'h0010,0), mk(0,0,0,0,10'h001,16'h00AA,0),
    mk(1,0,0,1,10'h020,16'hF00F,0),
    mk(3,5,0,0,10'h020,0,32'h00FF0F0A),        // R5 low mask byte
    mk(3,5,0,0,10'h021,0,32'h00FF0FA0),        // R5 high mask byte
    mk(2,7,0,1,10'h020,0,32'h0000A00A),        // R7 plain word
    mk(0,0,0,0,10'h000,16'h0000,0),
    mk(2,6,0,1,10'h020,0,32'h0000045F),        // R6 word compare
    mk(0,0,0,0,10'h000,16'h000E,0),
    mk(2,1,0,1,10'h020,0,32'h00005F5F),        // R1 blue only word
    mk(2,4,0,0,10'h020,0,32'h0000005F),        // R4 blue only byte
    mk(0,0,0,0,10'h000,16'h000F,0),
    mk(2,10,0,0,10'h020,0,32'h000000FF),       // R10 byte
    mk(2,10,0,1,10'h020,0,32'h0000FFFF),       // R10 word
    mk(1,0,0,0,10'h020,16'h0000,0),
    mk(3,10,0,0,10'h020,0,32'h00FF0F0A),       // R10 write blocked
    mk(0,0,0,0,10'h000,16'h0000,0),
    mk(1,0,1,0,10'h020,16'h0000,0),
    mk(3,8,1,0,10'h020,0,32'h00FF0FAA),        // R8 page 1
    mk(3,8,0,0,10'h020,0,32'h00FF0F0A),        // R8 page 0 untouched
    mk(1,0,0,0,10'h245,16'h0000,0),
    mk(3,8,0,0,10'h045,0,32'h00FF0FAA),        // R8 low address bits
    mk(0,0,0,0,10'h002,16'h0011,0), mk(0,0,0,0,10'h000,16'h0002,0),
    mk(1,0,0,0,10'h045,16'h0000,0),
    mk(3,1,0,0,10'h045,0,32'h00FF0FAA),        // R1 red disabled
    mk(0,0,0,0,10'h000,16'h0000,0),
    mk(1,0,0,0,10'h045,16'h0000,0),
    mk(3,1,0,0,10'h045,0,32'h00FF11AA),        // R1 red re-enabled
    mk(2,11,0,0,10'h045,0,32'h000000FF),       // R11 byte result
    mk(3,2,0,0,10'h010,0,32'h00FF0FC0)         // R2 earlier data kept
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [65:0] v);
    @(negedge clk);
    case (v[65:64])
      2'd0: begin cfg_we = 1'b1; cfg_sel = v[50:48]; cfg_wdata = v[47:32]; end
      2'd1: begin cpu_req = 1'b1; cpu_we = 1'b1; cpu_page = v[59]; cpu_word = v[58];
                  cpu_addr = v[57:48]; cpu_wdata = v[47:32]; end
      2'd2: begin cpu_req = 1'b1; cpu_we = 1'b0; cpu_page = v[59]; cpu_word = v[58];
                  cpu_addr = v[57:48]; end
      default: begin disp_page = v[59]; disp_addr = v[55:48]; end
    endcase
    @(negedge clk);
    cfg_we = 1'b0; cpu_req = 1'b0;
    if (v[65:64] == 2'd2) check($sformatf("R%0d", v[63:60]), {16'h0, cpu_rdata}, v[31:0]);
    if (v[65:64] == 2'd3) check($sformatf("R%0d", v[63:60]), disp_rdata, v[31:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 outputs idle in reset
    check("R12", {31'h0, cpu_rvalid}, 32'h0);
    check("R12", {31'h0, upd_valid}, 32'h0);
    check("R12", {16'h0, cpu_rdata}, 32'h0);
    rst_n = 1'b1;
    // R12 mode and tiles cleared: tile write lays zero in all planes
    apply(mk(1,0,0,0,10'h050,16'hFFFF,0));
    apply(mk(3,12,0,0,10'h050,0,32'h00000000));

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R9 update strobe for a word write at the top address of page 1
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_word = 1'b1; cpu_page = 1'b1; cpu_addr = 10'h0FF;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R9", {31'h0, upd_valid}, 32'h1);
    check("R9", {31'h0, upd_page}, 32'h1);
    check("R9", {24'h0, upd_addr}, 32'h0000_00FF);
    check("R9", {31'h0, upd_two}, 32'h1);
    @(negedge clk);
    check("R9", {31'h0, upd_valid}, 32'h0);
    // R5 word write wraps to plane address 0
    apply(mk(3,5,1,0,10'h000,0,32'h00FF11AA));
    apply(mk(3,5,1,0,10'h0FF,0,32'h00FF11AA));

    // R11 rvalid pulses for exactly one cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_word = 1'b0; cpu_page = 1'b0; cpu_addr = 10'h045;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R11", {31'h0, cpu_rvalid}, 32'h1);
    @(negedge clk);
    check("R11", {31'h0, cpu_rvalid}, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule